// File: doc/BRIEF.md
# Descriptor Ring Poll Interval Timer

This block paces the descriptor ring polling of a DMA engine. A free-running up-counter advances one step per clock. Each time it passes its all-ones value, it reloads from a programmable interval register and emits a one-cycle `poll_req` pulse. That pulse tells the DMA engine to fetch its receive and transmit descriptors again.

The interval register holds the two's complement of the wanted period, with an implied negative sign. Its low `IGN_LSB` bits take no part in the reload. Because of this, the code zero selects the longest period (2^CNT_W clocks) rather than turning the timer off.

A host port can read both registers and write both registers. Writes are honoured only while the stop or suspend status input is high. Reset clears only the control state and the pulse. The counter and interval values survive reset, and an explicit initialisation strobe sets them.

The control state machine has three states:

- `PT_COLD` is entered at reset. The counter is frozen and no poll is issued.
- `PT_IDLE` is primed but not running.
- `PT_RUN` is counting.

It has four transitions:

- *prime*: `PT_COLD` to `PT_IDLE` or `PT_RUN`, on `init_load` or on an accepted interval write. The target depends on `run_en`.
- *start*: `PT_IDLE` to `PT_RUN` when `run_en` is high.
- *halt*: `PT_RUN` to `PT_IDLE` when `run_en` is low.
- *reset*: any state to `PT_COLD`.

Top module: `ring_poll_timer`

## Requirements
- R1: After reset, the block sits in `PT_COLD` until it is primed. In that state the counter holds its value and `poll_req` stays low, even with `run_en` high.
- R2: A pulse on `init_load` sets both the interval and the counter to zero, and primes the state machine. The zeros are readable on the next cycle.
- R3: A host write (`host_wr` high, `host_sel` 0 = counter, 1 = interval, value in `host_wdata[CNT_W-1:0]`) changes the selected register on the next edge only if `stop_i` or `susp_i` is high. Otherwise the write is dropped.
- R4: `cnt_rdata` and `ivl_rdata` carry the register in bits CNT_W-1:0 and read zero in every bit above.
- R5: In `PT_RUN` the counter rises by one per clock. In `PT_IDLE` and `PT_COLD` it holds.
- R6: On the edge where a running counter is at all-ones, the counter loads the interval with bits IGN_LSB-1:0 forced to zero. In the same cycle `poll_req` goes high, for exactly one cycle.
- R7: In steady running, polls are spaced by 2^CNT_W minus the masked interval. Interval 0000h gives 65,536 clocks, FF07h gives 256, and FFFFh gives 16.
- R8: Asserting `rst_n` does not change the counter or the interval register.
- R9: `run_en` acts through the state register. Counting begins on the second edge after `run_en` rises, and stops after the first edge after it falls.
- R10: An accepted host counter write wins over a count step on the same edge. The next poll is then timed from the written value.
- R11: `init_load` wins over an accepted host write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state and pulse |
| run_en | input | 1 | Counter run enable |
| stop_i | input | 1 | Stop status; opens host writes |
| susp_i | input | 1 | Suspend status; opens host writes |
| init_load | input | 1 | Initialisation strobe: zero interval and counter |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Register select: 0 counter, 1 interval |
| host_wdata | input | BUS_W | Host write data |
| cnt_rdata | output | BUS_W | Counter read value |
| ivl_rdata | output | BUS_W | Interval read value |
| poll_req | output | 1 | One-cycle descriptor poll request |

## Verification
The bench builds the block with its defaults: a 32-bit host bus, a 16-bit counter, and 4 ignored interval bits. This keeps the real period range in play. The 16-clock minimum (interval FFFFh) allows many wraps and the low-bit masking to be checked within a few dozen cycles. The 256-clock case (FF07h) checks the masking of a nonzero low nibble. The full 65,536-clock period after an initialisation stays within the run budget, so the zero code's longest-period meaning is measured directly rather than inferred.

// File: rtl/ring_poll_pkg.sv
package ring_poll_pkg;

    // Control state of the poll timer.
    typedef enum logic [1:0] {
        PT_COLD = 2'd0,   // after reset, not yet primed
        PT_IDLE = 2'd1,   // primed, counter holding
        PT_RUN  = 2'd2    // counter advancing
    } pt_state_e;

    // Host register select encoding.
    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_IVL   = 1'b1
    } pt_sel_e;

endpackage

// File: rtl/ring_poll_fsm.sv
module ring_poll_fsm
    import ring_poll_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_en,
    input  logic      prime,
    output pt_state_e state_q,
    output logic      cnt_run
);

    pt_state_e state_d;

    // State register: the only part of the control path cleared by reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PT_COLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: prime, start, halt.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PT_COLD: begin
                if (prime) begin
                    state_d = run_en ? PT_RUN : PT_IDLE;
                end
            end
            PT_IDLE: begin
                if (run_en) begin
                    state_d = PT_RUN;
                end
            end
            PT_RUN: begin
                if (!run_en) begin
                    state_d = PT_IDLE;
                end
            end
            default: state_d = PT_COLD;
        endcase
    end

    // Outputs decoded from the registered state only.
    always_comb begin
        cnt_run = 1'b0;
        unique case (state_q)
            PT_COLD: cnt_run = 1'b0;
            PT_IDLE: cnt_run = 1'b0;
            PT_RUN:  cnt_run = 1'b1;
            default: cnt_run = 1'b0;
        endcase
    end

endmodule

// File: rtl/ring_poll_host.sv
module ring_poll_host
    import ring_poll_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             stop_i,
    input  logic             susp_i,
    input  logic             host_wr,
    input  logic             host_sel,
    input  logic [BUS_W-1:0] host_wdata,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] ivl_q,
    output logic             wr_cnt,
    output logic             wr_ivl,
    output logic [CNT_W-1:0] wval,
    output logic [BUS_W-1:0] cnt_rdata,
    output logic [BUS_W-1:0] ivl_rdata
);

    localparam int PAD_W = BUS_W - CNT_W;

    logic gate_open;

    // Writes pass only while the engine is stopped or suspended.
    assign gate_open = stop_i | susp_i;
    assign wr_cnt    = host_wr & gate_open & (pt_sel_e'(host_sel) == SEL_COUNT);
    assign wr_ivl    = host_wr & gate_open & (pt_sel_e'(host_sel) == SEL_IVL);
    assign wval      = host_wdata[CNT_W-1:0];

    generate
        if (PAD_W > 0) begin : g_pad
            logic unused_hi;
            assign unused_hi = ^host_wdata[BUS_W-1:CNT_W];
            assign cnt_rdata = {{PAD_W{1'b0}}, cnt_q};
            assign ivl_rdata = {{PAD_W{1'b0}}, ivl_q};
        end else begin : g_nopad
            assign cnt_rdata = cnt_q;
            assign ivl_rdata = ivl_q;
        end
    endgenerate

endmodule

// File: rtl/ring_poll_ivl.sv
module ring_poll_ivl #(
    parameter int CNT_W   = 16,
    parameter int IGN_LSB = 4
) (
    input  logic             clk,
    input  logic             init_ld,
    input  logic             wr_ivl,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] ivl_q,
    output logic [CNT_W-1:0] reload_val
);

    // Value survives reset; only the init strobe or a host write sets it.
    always_ff @(posedge clk) begin
        if (init_ld) begin
            ivl_q <= '0;
        end else if (wr_ivl) begin
            ivl_q <= wval;
        end
    end

    generate
        if (IGN_LSB > 0) begin : g_mask
            assign reload_val = {ivl_q[CNT_W-1:IGN_LSB], {IGN_LSB{1'b0}}};
        end else begin : g_full
            assign reload_val = ivl_q;
        end
    endgenerate

endmodule

// File: rtl/ring_poll_cnt.sv
module ring_poll_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_run,
    input  logic             init_ld,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wval,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             poll_q
);

    logic at_top;
    logic wrap;

    assign at_top = &cnt_q;
    // A wrap counts only when the reload really happens.
    assign wrap   = cnt_run & at_top & ~init_ld & ~wr_cnt;

    // Counter value survives reset. Priority: init, host write, count.
    always_ff @(posedge clk) begin
        if (init_ld) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wval;
        end else if (cnt_run) begin
            cnt_q <= at_top ? reload_val : cnt_q + 1'b1;
        end
    end

    // Pulse is registered so it appears together with the reloaded count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_q <= 1'b0;
        end else begin
            poll_q <= wrap;
        end
    end

endmodule

// File: rtl/ring_poll_timer.sv
module ring_poll_timer
    import ring_poll_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int CNT_W   = 16,
    parameter int IGN_LSB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             stop_i,
    input  logic             susp_i,
    input  logic             init_load,
    input  logic             host_wr,
    input  logic             host_sel,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] cnt_rdata,
    output logic [BUS_W-1:0] ivl_rdata,
    output logic             poll_req
);

    pt_state_e        state;
    logic             cnt_run;
    logic             wr_cnt_ok;
    logic             wr_ivl_ok;
    logic [CNT_W-1:0] wval;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ivl_q;
    logic [CNT_W-1:0] reload_val;
    logic             prime;

    assign prime = init_load | wr_ivl_ok;

    ring_poll_host #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_host (
        .stop_i     (stop_i),
        .susp_i     (susp_i),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .cnt_q      (cnt_q),
        .ivl_q      (ivl_q),
        .wr_cnt     (wr_cnt_ok),
        .wr_ivl     (wr_ivl_ok),
        .wval       (wval),
        .cnt_rdata  (cnt_rdata),
        .ivl_rdata  (ivl_rdata)
    );

    ring_poll_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .prime   (prime),
        .state_q (state),
        .cnt_run (cnt_run)
    );

    ring_poll_ivl #(.CNT_W(CNT_W), .IGN_LSB(IGN_LSB)) u_ivl (
        .clk        (clk),
        .init_ld    (init_load),
        .wr_ivl     (wr_ivl_ok),
        .wval       (wval),
        .ivl_q      (ivl_q),
        .reload_val (reload_val)
    );

    ring_poll_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_run    (cnt_run),
        .init_ld    (init_load),
        .wr_cnt     (wr_cnt_ok),
        .wval       (wval),
        .reload_val (reload_val),
        .cnt_q      (cnt_q),
        .poll_q     (poll_req)
    );

endmodule

// File: rtl/ring_poll_timer_chk.sv
module ring_poll_timer_chk
    import ring_poll_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int CNT_W   = 16,
    parameter int IGN_LSB = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             stop_i,
    input logic             susp_i,
    input logic             init_load,
    input logic             host_wr,
    input logic             host_sel,
    input logic [BUS_W-1:0] cnt_rdata,
    input logic [BUS_W-1:0] ivl_rdata,
    input logic             poll_req,
    input pt_state_e        state,
    input logic             cnt_run,
    input logic             wr_cnt_ok
);

    localparam logic [CNT_W-1:0] MASK  = {CNT_W{1'b1}} << IGN_LSB;
    localparam logic [CNT_W-1:0] ALL1  = {CNT_W{1'b1}};

    // R6
    poll_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> !poll_req);

    // R6
    poll_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> (cnt_rdata[CNT_W-1:0] == ($past(ivl_rdata[CNT_W-1:0]) & MASK)));

    // R3
    ivl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !stop_i && !susp_i && !init_load) |=> $stable(ivl_rdata));

    // R3
    cnt_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && !stop_i && !susp_i && !init_load && !cnt_run)
        |=> $stable(cnt_rdata));

    // R2
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_load |=> (ivl_rdata == '0) && (cnt_rdata == '0));

    // R1
    cold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PT_COLD && !init_load && !host_wr) |=> ($stable(cnt_rdata) && !poll_req));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_run && !init_load && !wr_cnt_ok && cnt_rdata[CNT_W-1:0] != ALL1)
        |=> cnt_rdata[CNT_W-1:0] == $past(cnt_rdata[CNT_W-1:0]) + 1'b1);

    // R9
    halt_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && state != PT_COLD) |=> state == PT_IDLE);

endmodule

bind ring_poll_timer ring_poll_timer_chk #(
    .BUS_W(BUS_W), .CNT_W(CNT_W), .IGN_LSB(IGN_LSB)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .stop_i    (stop_i),
    .susp_i    (susp_i),
    .init_load (init_load),
    .host_wr   (host_wr),
    .host_sel  (host_sel),
    .cnt_rdata (cnt_rdata),
    .ivl_rdata (ivl_rdata),
    .poll_req  (poll_req),
    .state     (state),
    .cnt_run   (cnt_run),
    .wr_cnt_ok (wr_cnt_ok)
);

// File: tb/test_ring_poll_timer.sv
`timescale 1ns/100ps
module test_ring_poll_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        stop_i = 1'b0;
    logic        susp_i = 1'b0;
    logic        init_load = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] cnt_rdata;
    logic [31:0] ivl_rdata;
    logic        poll_req;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int exp_q[$];
    int exp_cyc;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ring_poll_timer i_ring_poll_timer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .stop_i(stop_i), .susp_i(susp_i),
        .init_load(init_load), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .cnt_rdata(cnt_rdata), .ivl_rdata(ivl_rdata),
        .poll_req(poll_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic host_write(input logic sel, input logic [31:0] data);
        host_wr = 1'b1; host_sel = sel; host_wdata = data;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    // Monitor: pops expected poll cycles and compares (R6, R7).
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && cyc > exp_q[0]) begin
                checks++; fails++;
                $display("FAIL R7 missed poll actual=none expected=%0d", exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (poll_req) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R6 unexpected poll actual=%0d expected=none", cyc);
                end else begin
                    exp_cyc = exp_q.pop_front();
                    if (exp_cyc != cyc) begin
                        fails++;
                        $display("FAIL R7 poll cycle actual=%0d expected=%0d", cyc, exp_cyc);
                    end
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n0;
        int m;
        int a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 poll low after reset", {31'b0, poll_req}, 32'h0);

        // R2: init strobe zeroes both registers; R4 upper bits zero.
        init_load = 1'b1; @(negedge clk); init_load = 1'b0;
        chk("R2 R4 interval after init", ivl_rdata, 32'h0);
        chk("R2 R4 counter after init", cnt_rdata, 32'h0);

        // R3: writes dropped with stop and suspend low.
        host_write(1'b1, 32'h0000FFF0);
        host_write(1'b0, 32'h00001234);
        chk("R3 interval write dropped", ivl_rdata, 32'h0);
        chk("R3 counter write dropped", cnt_rdata, 32'h0);

        // R3: writes accepted under suspend; R4 upper bits discarded.
        susp_i = 1'b1;
        host_write(1'b1, 32'hABCDFF07);
        host_write(1'b0, 32'h5555FFF0);
        susp_i = 1'b0;
        chk("R3 R4 interval written", ivl_rdata, 32'h0000FF07);
        chk("R3 R4 counter written", cnt_rdata, 32'h0000FFF0);

        // R8: reset keeps both registers.
        rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk("R8 interval kept over reset", ivl_rdata, 32'h0000FF07);
        chk("R8 counter kept over reset", cnt_rdata, 32'h0000FFF0);

        // R1: cold state ignores run_en (counter would wrap within 16 clocks).
        run_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 counter frozen while cold", cnt_rdata, 32'h0000FFF0);
        run_en = 1'b0;
        @(negedge clk);

        // R9 prime by accepted interval write, then start.
        stop_i = 1'b1;
        host_write(1'b1, 32'h0000FF07);
        stop_i = 1'b0;
        n0 = cyc;
        exp_q.push_back(n0 + 17);
        exp_q.push_back(n0 + 17 + 256);
        exp_q.push_back(n0 + 17 + 512);
        run_en = 1'b1;
        wait_cyc(n0 + 17);
        chk("R6 reload with low bits cleared", cnt_rdata, 32'h0000FF00);
        wait_cyc(n0 + 530);
        run_en = 1'b0;
        wait_cyc(n0 + 533);
        chk("R5 R9 counter after halt", cnt_rdata, 32'h0000FF02);
        repeat (300) @(negedge clk);
        chk("R5 counter holds while idle", cnt_rdata, 32'h0000FF02);

        // R7 shortest period with ignored low bits, R10 write wins over count.
        stop_i = 1'b1;
        host_write(1'b1, 32'h0000FFFF);
        host_write(1'b0, 32'h0000FFFE);
        stop_i = 1'b0;
        n0 = cyc;
        exp_q.push_back(n0 + 3);
        exp_q.push_back(n0 + 19);
        exp_q.push_back(n0 + 35);
        exp_q.push_back(n0 + 45);
        exp_q.push_back(n0 + 61);
        exp_q.push_back(n0 + 77);
        run_en = 1'b1;
        wait_cyc(n0 + 3);
        chk("R6 reload from FFFF interval", cnt_rdata, 32'h0000FFF0);
        wait_cyc(n0 + 36);
        stop_i = 1'b1;
        host_write(1'b0, 32'h0000FFF8);
        stop_i = 1'b0;
        chk("R10 host write beats count step", cnt_rdata, 32'h0000FFF8);

        // R11 init beats host write; R7 zero interval gives 65536 clocks.
        wait_cyc(n0 + 78);
        m = cyc;
        init_load = 1'b1; stop_i = 1'b1;
        host_wr = 1'b1; host_sel = 1'b1; host_wdata = 32'h0000FFF0;
        @(negedge clk);
        init_load = 1'b0; stop_i = 1'b0; host_wr = 1'b0; host_wdata = '0;
        chk("R11 init wins over interval write", ivl_rdata, 32'h0);
        chk("R2 counter cleared while running", cnt_rdata, 32'h0);
        exp_q.push_back(m + 65537);
        a = m + 65537;
        wait_cyc(a);
        chk("R7 reload after full period", cnt_rdata, 32'h0);
        wait_cyc(a + 2);
        run_en = 1'b0;
        repeat (40) @(negedge clk);
        chk("R7 all expected polls seen", exp_q.size(), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule